// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block is the digital back end of a flash analog-to-digital converter. It takes the 127 comparator outputs, which together form a thermometer code, and produces a 7-bit data word. The rising edge of a convert strobe captures the comparator states. The encoding logic that follows the capture register is purely combinational, and there is no output data register. One strobe therefore gives a complete conversion, and the new word appears right after that strobe's rising edge instead of one strobe later.

Comparator line `i` (0 to 126) is asserted when the analog input lies below threshold `i+1`. The most positive input leaves every line clear, and full scale sets every line. The code is the number of asserted lines. Because the lines are counted rather than searched for an edge, one stray or missing line moves the code by exactly one.

Two active-low, static controls choose the output format. One complements the most significant bit and the other complements the six lower bits. Together they give straight binary, offset two's complement, and the inverted form of each.

Top module: `flash_encoder`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe edge, the captured sample is all clear, so `data_o` shows code 0 in the selected format.
- R2: The comparator lines are captured on the rising edge of `conv_i`, and `data_o` shows the encoding of that sample within the same strobe period, with no second strobe needed.
- R3: Between rising edges of `conv_i`, `data_o` holds the previous result even when `therm_i` changes, including across the falling edge of the strobe.
- R4: For a clean thermometer with the lowest `k` lines set, the code is `k`.
- R5: All lines clear gives code 0 and all lines set gives code 127, which covers inputs beyond either end of the range.
- R6: The code is the count of asserted lines, so one stray set line above the run gives `k+1` and one clear line inside the run gives `k-1`.
- R7: With `msb_inv_n`=1 and `lsb_inv_n`=1 the output is straight binary: bit 6 is the code MSB and bits 5:0 are the code's lower bits.
- R8: With `msb_inv_n`=0 and `lsb_inv_n`=1 only bit 6 is complemented, which gives offset two's complement (code 0 becomes 1000000).
- R9: With `msb_inv_n`=1 and `lsb_inv_n`=0 only bits 5:0 are complemented (code 0 becomes 0111111).
- R10: With both controls at 0 all seven bits are complemented (code 0 becomes 1111111).
- R11: The mid-scale boundary falls between 63 lines (binary 0111111) and 64 lines (binary 1000000), and it maps through each format in the same way.
- R12: The format controls are static. A change made while `rst_n` is low shows at once on `data_o`, and the controls do not change between strobes during operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| conv_i | input | 1 | Convert strobe; its rising edge captures the comparators |
| rst_n | input | 1 | Asynchronous active-low clear of the captured sample |
| therm_i | input | 127 | Comparator lines; bit i is set when the input is below threshold i+1 |
| msb_inv_n | input | 1 | Active-low complement of output bit 6 |
| lsb_inv_n | input | 1 | Active-low complement of output bits 5:0 |
| data_o | output | 7 | Encoded conversion result |

## Verification
The assertions assume that the format controls change only under reset, and that a strobe edge seen after reset captures exactly the `therm_i` value sampled at that edge. The bench keeps to both rules. It changes the format only inside a reset window, and it issues one strobe pulse in that window so the static-control check has a reset edge behind it. It also changes `therm_i` only away from rising strobe edges. The full-scale and zero-scale checks use `$past` on the previous strobe, which is valid because every captured sample stays on the outputs until the next rising edge.

// File: rtl/flash_encoder.sv
module flash_encoder #(
  parameter int BITS = 7
) (
  input  logic                   conv_i,
  input  logic                   rst_n,
  input  logic [(2**BITS)-2:0]   therm_i,
  input  logic                   msb_inv_n,
  input  logic                   lsb_inv_n,
  output logic [BITS-1:0]        data_o
);
  localparam int LINES = (2**BITS) - 1;

  logic [LINES-1:0] sample;
  logic [BITS-1:0]  ones;

  always_ff @(posedge conv_i or negedge rst_n)
    if (!rst_n) sample <= '0;
    else        sample <= therm_i;

  always_comb begin
    ones = '0;
    for (int i = 0; i < LINES; i++)
      ones = ones + BITS'(sample[i]);
  end

  assign data_o = {ones[BITS-1] ^ ~msb_inv_n,
                   ones[BITS-2:0] ^ {(BITS-1){~lsb_inv_n}}};

  p_ctrl_static_r12: assert property (@(posedge conv_i) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(msb_inv_n) && $stable(lsb_inv_n)));

  p_reset_code_r1: assert property (@(posedge conv_i) disable iff (!rst_n)
    !$past(rst_n) |-> data_o == {~msb_inv_n, {(BITS-1){~lsb_inv_n}}});

  p_full_scale_r5: assert property (@(posedge conv_i) disable iff (!rst_n)
    ($past(rst_n) && $past(&therm_i) && msb_inv_n && lsb_inv_n) |-> data_o == '1);

  p_zero_scale_r5: assert property (@(posedge conv_i) disable iff (!rst_n)
    ($past(rst_n) && $past(therm_i == '0) && msb_inv_n && lsb_inv_n) |-> data_o == '0);

  p_offset_mid_r8: assert property (@(posedge conv_i) disable iff (!rst_n)
    ($past(rst_n) && $past(therm_i == {{(LINES/2){1'b0}}, {(LINES/2+1){1'b1}}})
     && !msb_inv_n && lsb_inv_n) |-> data_o == '0);
endmodule

// File: tb/test_flash_encoder.sv
module test_flash_encoder;
  localparam int CLK_PERIOD = 20;
  localparam int BITS = 7;
  localparam int LINES = (2**BITS) - 1;

  logic clk = 1'b0;
  logic conv_i = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] therm_i = '0;
  logic msb_inv_n = 1'b1;
  logic lsb_inv_n = 1'b1;
  logic [BITS-1:0] data_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  flash_encoder #(.BITS(BITS)) i_flash_encoder (
    .conv_i(conv_i), .rst_n(rst_n), .therm_i(therm_i),
    .msb_inv_n(msb_inv_n), .lsb_inv_n(lsb_inv_n), .data_o(data_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {msb_inv_n, lsb_inv_n, lines set (7b), expected (7b)}
  localparam logic [15:0] VEC [16] = '{
    {2'b11, 7'd0,   7'b0000000},  // R7 R5
    {2'b11, 7'd1,   7'b0000001},  // R4
    {2'b11, 7'd63,  7'b0111111},  // R11
    {2'b11, 7'd64,  7'b1000000},  // R11
    {2'b11, 7'd127, 7'b1111111},  // R5
    {2'b01, 7'd0,   7'b1000000},  // R8
    {2'b01, 7'd63,  7'b1111111},  // R8 R11
    {2'b01, 7'd64,  7'b0000000},  // R8 R11
    {2'b01, 7'd127, 7'b0111111},  // R8
    {2'b10, 7'd0,   7'b0111111},  // R9
    {2'b10, 7'd1,   7'b0111110},  // R9
    {2'b10, 7'd64,  7'b1111111},  // R9 R11
    {2'b10, 7'd127, 7'b1000000},  // R9
    {2'b00, 7'd0,   7'b1111111},  // R10
    {2'b00, 7'd5,   7'b1111010},  // R10
    {2'b00, 7'd127, 7'b0000000}   // R10
  };

  function automatic logic [LINES-1:0] therm_of(int k);
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = (i < k);
    return v;
  endfunction

  task automatic check(string req, logic [BITS-1:0] act, logic [BITS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic set_format(logic m, logic l);
    rst_n = 1'b0;
    #(CLK_PERIOD);
    conv_i = 1'b1;
    #(CLK_PERIOD/2);
    conv_i = 1'b0;
    msb_inv_n = m;
    lsb_inv_n = l;
    #(CLK_PERIOD/2);
    check("R12", data_o, {~m, {(BITS-1){~l}}});
    rst_n = 1'b1;
    #(CLK_PERIOD);
  endtask

  task automatic strobe(logic [LINES-1:0] v);
    therm_i = v;
    #(CLK_PERIOD/2);
    conv_i = 1'b1;
    #1;
  endtask

  task automatic unstrobe();
    #(CLK_PERIOD/2 - 1);
    conv_i = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    therm_i = therm_of(90);
    #(CLK_PERIOD);
    check("R1 reset straight", data_o, 7'b0000000);
    rst_n = 1'b1;
    #(CLK_PERIOD);
    check("R1 after release", data_o, 7'b0000000);

    set_format(1'b0, 1'b1);
    check("R1 reset offset", data_o, 7'b1000000);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][15] !== msb_inv_n || VEC[i][14] !== lsb_inv_n)
        set_format(VEC[i][15], VEC[i][14]);
      strobe(therm_of(int'(VEC[i][13:7])));
      check("R2 R4 vector", data_o, VEC[i][6:0]);
      unstrobe();
    end

    set_format(1'b1, 1'b1);
    strobe(therm_of(37));
    check("R2 zero latency", data_o, 7'd37);
    therm_i = therm_of(100);
    #2;
    check("R3 hold while high", data_o, 7'd37);
    unstrobe();
    check("R3 hold after fall", data_o, 7'd37);
    strobe(therm_of(100));
    check("R2 next strobe", data_o, 7'd100);
    unstrobe();

    begin
      logic [LINES-1:0] v;
      v = therm_of(10);
      v[40] = 1'b1;
      strobe(v);
      check("R6 stray set line", data_o, 7'd11);
      unstrobe();
      v = therm_of(20);
      v[5] = 1'b0;
      strobe(v);
      check("R6 hole in run", data_o, 7'd19);
      unstrobe();
    end

    set_format(1'b0, 1'b0);
    strobe(therm_of(64));
    check("R10 R11 mid inverted", data_o, 7'b0111111);
    unstrobe();

    finish_run();
  end
endmodule